// File: doc/BRIEF.md
# DRAM Power-State Checker

This block is a synchronous monitor placed beside a graphics SDRAM controller or device model. On every rising clock edge it looks at the clock-enable level, compares it with the level it saw at the edge before, and reads a decoded command code and an "any bank open" flag. From these it follows the device through its idle and active operation, both kinds of power down, self refresh, and the two exit windows during which only no-operation commands may be issued. The exit windows have programmable lengths.

The monitor reports which state the device is in. It shows whether the current power down, or the power-down exit window, came from an open bank. It pulses an error output for every clock edge whose clock-enable pair and command do not form a defined transition. Decoding commands from raw pins and checking the data path are left to other logic.

Top module: `pwrStateMon`

## Requirements
- R1: Synchronous active-low reset sets `monState` to 0 (idle), drives `pdActive` and `errPulse` low, and takes the previous clock-enable level as high, so a first edge with clock enable high raises no error. State codes: 0 idle, 1 bank active, 2 power down, 3 self refresh, 4 power-down exit window, 5 self-refresh exit window.
- R2: Command codes are 0 DESEL, 1 NOP, 2 ACT, 3 RD, 4 WR, 5 PRE, 6 AREF, 7 MRS. While idle or active with clock enable high at both edges, any command is legal and `monState` becomes 1 if `bankActive` was high at that edge, else 0.
- R3: From idle or active, clock enable going high to low with DESEL or NOP enters power down (state 2). `pdActive` then equals the `bankActive` level sampled at that edge.
- R4: From idle or active, clock enable going high to low with AREF while `bankActive` is low enters self refresh (state 3).
- R5: In power down or self refresh with clock enable low, the state is held with no error, whatever command is presented.
- R6: A rising clock enable in power down loads `xpnCycles` and enters state 4 for that many edges. The monitor then returns to state 1 if the power down was entered with a bank open, else to state 0, whatever `bankActive` shows. A load of 0 returns at once.
- R7: A rising clock enable in self refresh loads `srxCycles` and enters state 5 for that many edges, then returns to state 0. A load of 0 returns at once.
- R8: During either exit window, an edge whose command is not DESEL or NOP, or an edge with clock enable low, raises an error. The window length does not change.
- R9: A rising clock enable in power down or self refresh with a command other than DESEL or NOP raises an error. The exit window is still entered.
- R10: From idle or active, the following raise an error and enter no low-power state: clock enable falling with any command other than DESEL, NOP, or AREF while all banks are idle; or clock enable low at the previous edge.
- R11: `errPulse` is registered. It is high for exactly the cycle after each offending edge and low after a legal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; all sampling on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level observed at the device |
| cmdCode | input | 3 | Decoded command code at this edge |
| bankActive | input | 1 | High when at least one bank is open |
| xpnCycles | input | XPN_W | Length of the power-down exit window in edges |
| srxCycles | input | CNT_W | Length of the self-refresh exit window in edges |
| monState | output | 3 | Current tracked state code |
| pdActive | output | 1 | Power down or its exit window came from an open bank |
| errPulse | output | 1 | One-cycle pulse per illegal edge |

## Verification
Each result is registered once. The state, power-down flavour and error for the inputs at a given edge therefore appear just after that edge and stay until the next one. The driver sets inputs on the falling edge and queues the expected outputs for that edge. The monitor takes one queued item a short delay after every rising edge, so every comparison lands in the one cycle where that edge's result is valid. Exit-window lengths are counted edge by edge in the driver, including a 1000-edge self-refresh window whose final edge carries an illegal command.

// File: rtl/pwrMonPkg.sv
package pwrMonPkg;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_AREF  = 3'd6,
    CMD_MRS   = 3'd7
  } cmdCode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PDN    = 3'd2,
    ST_SREF   = 3'd3,
    ST_PDX    = 3'd4,
    ST_SRX    = 3'd5
  } monState_e;

  // strobes from control to the window counter
  typedef struct packed {
    logic loadXpn;
    logic loadSrx;
    logic decr;
  } cntCtl_t;

  function automatic logic isQuietCmd(input logic [2:0] code);
    return (code == CMD_DESEL) || (code == CMD_NOP);
  endfunction

endpackage

// File: rtl/pwrMonCnt.sv
module pwrMonCnt
  import pwrMonPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int XPN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  cntCtl_t          ctl,
  input  logic [XPN_W-1:0] xpnCycles,
  input  logic [CNT_W-1:0] srxCycles,
  output logic             ckePrev,
  output logic             winLast,
  output logic             xpnZero,
  output logic             srxZero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      winCnt  <= '0;
    end else begin
      ckePrev <= cke;
      if (ctl.loadXpn) begin
        winCnt <= CNT_W'(xpnCycles);
      end else if (ctl.loadSrx) begin
        winCnt <= srxCycles;
      end else if (ctl.decr && (winCnt != '0)) begin
        winCnt <= winCnt - ONE;
      end
    end
  end

  assign winLast = (winCnt <= ONE);
  assign xpnZero = (xpnCycles == '0);
  assign srxZero = (srxCycles == '0);

endmodule

// File: rtl/pwrMonCtl.sv
module pwrMonCtl
  import pwrMonPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       ckePrev,
  input  logic [2:0] cmdCode,
  input  logic       bankActive,
  input  logic       winLast,
  input  logic       xpnZero,
  input  logic       srxZero,
  output cntCtl_t    ctl,
  output logic [2:0] monState,
  output logic       pdActive,
  output logic       errPulse
);

  monState_e curState, nxtState;
  logic      fromOpen, fromOpenNxt;
  logic      errNxt;
  logic      quiet;
  monState_e liveState;
  monState_e pdReturn;

  assign quiet     = isQuietCmd(cmdCode);
  assign liveState = bankActive ? ST_ACTIVE : ST_IDLE;
  assign pdReturn  = fromOpen ? ST_ACTIVE : ST_IDLE;

  always_comb begin
    nxtState    = curState;
    fromOpenNxt = fromOpen;
    errNxt      = 1'b0;
    ctl         = '0;
    unique case (curState)
      ST_IDLE, ST_ACTIVE: begin
        nxtState = liveState;
        if (ckePrev && !cke) begin
          if (quiet) begin
            nxtState    = ST_PDN;
            fromOpenNxt = bankActive;
          end else if ((cmdCode == CMD_AREF) && !bankActive) begin
            nxtState = ST_SREF;
          end else begin
            errNxt = 1'b1;
          end
        end else if (!ckePrev) begin
          errNxt = 1'b1;
        end
      end
      ST_PDN: begin
        if (cke) begin
          errNxt = !quiet;
          if (xpnZero) begin
            nxtState = pdReturn;
          end else begin
            nxtState    = ST_PDX;
            ctl.loadXpn = 1'b1;
          end
        end
      end
      ST_SREF: begin
        if (cke) begin
          errNxt = !quiet;
          if (srxZero) begin
            nxtState = ST_IDLE;
          end else begin
            nxtState    = ST_SRX;
            ctl.loadSrx = 1'b1;
          end
        end
      end
      ST_PDX, ST_SRX: begin
        errNxt   = !quiet || !cke;
        ctl.decr = 1'b1;
        if (winLast) begin
          nxtState = (curState == ST_PDX) ? pdReturn : ST_IDLE;
        end
      end
      default: begin
        nxtState = ST_IDLE;
        errNxt   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      fromOpen <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      curState <= nxtState;
      fromOpen <= fromOpenNxt;
      errPulse <= errNxt;
    end
  end

  assign monState = curState;
  assign pdActive = fromOpen && ((curState == ST_PDN) || (curState == ST_PDX));

endmodule

// File: rtl/pwrStateMon.sv
module pwrStateMon
  import pwrMonPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int XPN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic [2:0]       cmdCode,
  input  logic             bankActive,
  input  logic [XPN_W-1:0] xpnCycles,
  input  logic [CNT_W-1:0] srxCycles,
  output logic [2:0]       monState,
  output logic             pdActive,
  output logic             errPulse
);

  cntCtl_t ctl;
  logic    ckePrev;
  logic    winLast;
  logic    xpnZero;
  logic    srxZero;

  pwrMonCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cke       (cke),
    .ckePrev   (ckePrev),
    .cmdCode   (cmdCode),
    .bankActive(bankActive),
    .winLast   (winLast),
    .xpnZero   (xpnZero),
    .srxZero   (srxZero),
    .ctl       (ctl),
    .monState  (monState),
    .pdActive  (pdActive),
    .errPulse  (errPulse)
  );

  pwrMonCnt #(
    .CNT_W(CNT_W),
    .XPN_W(XPN_W)
  ) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .ctl      (ctl),
    .xpnCycles(xpnCycles),
    .srxCycles(srxCycles),
    .ckePrev  (ckePrev),
    .winLast  (winLast),
    .xpnZero  (xpnZero),
    .srxZero  (srxZero)
  );

endmodule

// File: rtl/pwrStateMon_chk.sv
module pwrStateMon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       ckePrev,
  input logic [2:0] cmdCode,
  input logic       bankActive,
  input logic [2:0] monState,
  input logic       pdActive,
  input logic       errPulse
);

  logic quiet;
  logic normal;
  logic lowPwr;
  logic inWin;

  assign quiet  = (cmdCode == 3'd0) || (cmdCode == 3'd1);
  assign normal = (monState == 3'd0) || (monState == 3'd1);
  assign lowPwr = (monState == 3'd2) || (monState == 3'd3);
  assign inWin  = (monState == 3'd4) || (monState == 3'd5);

  AST_NORMAL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (normal && ckePrev && cke) |=> (!errPulse && (monState == {2'b00, $past(bankActive)}))); // R2

  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (normal && ckePrev && !cke && quiet) |=> ((monState == 3'd2) && (pdActive == $past(bankActive)))); // R3

  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (normal && ckePrev && !cke && (cmdCode == 3'd6) && !bankActive) |=> (monState == 3'd3)); // R4

  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lowPwr && !cke) |=> (!errPulse && $stable(monState))); // R5

  AST_WIN_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && (!quiet || !cke)) |=> errPulse); // R8

  AST_BAD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (lowPwr && cke && !quiet) |=> errPulse); // R9

  AST_PDTYPE_SCOPE: assert property (@(posedge clk) disable iff (!rstN)
    pdActive |-> ((monState == 3'd2) || (monState == 3'd4))); // R3

endmodule

bind pwrStateMon pwrStateMon_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cke       (cke),
  .ckePrev   (ckePrev),
  .cmdCode   (cmdCode),
  .bankActive(bankActive),
  .monState  (monState),
  .pdActive  (pdActive),
  .errPulse  (errPulse)
);

// File: tb/pwrStateMon_tb.sv
`timescale 1ns/1ps
module pwrStateMon_tb;
  import pwrMonPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1;
  logic [2:0]  cmdCode = 3'd1;
  logic        bankActive = 1'b0;
  logic [7:0]  xpnCycles = 8'd3;
  logic [15:0] srxCycles = 16'd5;
  logic [2:0]  monState;
  logic        pdActive;
  logic        errPulse;

  int vecCnt = 0;
  int badCnt = 0;

  typedef struct {
    logic [2:0] st;
    logic       pd;
    logic       er;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  always #2 clk = ~clk;  // 250 MHz

  pwrStateMon u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cke       (cke),
    .cmdCode   (cmdCode),
    .bankActive(bankActive),
    .xpnCycles (xpnCycles),
    .srxCycles (srxCycles),
    .monState  (monState),
    .pdActive  (pdActive),
    .errPulse  (errPulse)
  );

  function automatic void compare(input string tag, input logic [2:0] st, input logic pd, input logic er);
    vecCnt++;
    if (monState !== st || pdActive !== pd || errPulse !== er) begin
      badCnt++;
      $display("FAIL %s: state/pd/err actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, monState, pdActive, errPulse, st, pd, er);
    end
  endfunction

  // driver: apply one edge of stimulus and queue its expected result
  task automatic step(input logic c, input logic [2:0] k, input logic ba,
                      input logic [2:0] st, input logic pd, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    cke = c;
    cmdCode = k;
    bankActive = ba;
    e.st = st; e.pd = pd; e.er = er; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: result of each edge is checked shortly after that edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        compare(e.tag, e.st, e.pd, e.er);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    badCnt++;
    vecCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset", ST_IDLE, 1'b0, 1'b0);
    rstN = 1'b1;

    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R1 first edge");
    step(1, CMD_ACT, 1, ST_ACTIVE, 0, 0, "R2 act");
    step(1, CMD_RD,  1, ST_ACTIVE, 0, 0, "R2 rd");
    step(1, CMD_PRE, 0, ST_IDLE, 0, 0, "R2 pre");

    // active power down and exit
    step(1, CMD_NOP, 1, ST_ACTIVE, 0, 0, "R2");
    step(0, CMD_NOP, 1, ST_PDN, 1, 0, "R3 apd entry");
    step(0, CMD_RD,  1, ST_PDN, 1, 0, "R5 hold");
    step(0, CMD_ACT, 0, ST_PDN, 1, 0, "R5 hold");
    step(1, CMD_NOP, 0, ST_PDX, 1, 0, "R6 exit");
    step(1, CMD_NOP, 0, ST_PDX, 1, 0, "R6 win1");
    step(1, CMD_DESEL, 0, ST_PDX, 1, 0, "R6 win2");
    step(1, CMD_NOP, 0, ST_ACTIVE, 0, 0, "R6 back to active");

    // precharge power down, bad command in window
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R2");
    step(0, CMD_DESEL, 0, ST_PDN, 0, 0, "R3 ppd entry");
    step(1, CMD_NOP, 0, ST_PDX, 0, 0, "R6 exit");
    step(1, CMD_WR, 0, ST_PDX, 0, 1, "R8 wr in window");
    step(1, CMD_NOP, 0, ST_PDX, 0, 0, "R11 pulse ends");
    step(1, CMD_NOP, 1, ST_IDLE, 0, 0, "R6 back to idle");

    // self refresh, short window
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R2");
    step(0, CMD_AREF, 0, ST_SREF, 0, 0, "R4 sr entry");
    step(0, CMD_MRS, 0, ST_SREF, 0, 0, "R5 hold");
    step(1, CMD_NOP, 0, ST_SRX, 0, 0, "R7 exit");
    step(0, CMD_NOP, 0, ST_SRX, 0, 1, "R8 cke low");
    step(1, CMD_ACT, 0, ST_SRX, 0, 1, "R8 act");
    step(1, CMD_NOP, 0, ST_SRX, 0, 0, "R7 win");
    step(1, CMD_NOP, 0, ST_SRX, 0, 0, "R7 win");
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R7 back");

    // illegal transitions from normal operation
    step(1, CMD_NOP, 1, ST_ACTIVE, 0, 0, "R2");
    step(0, CMD_AREF, 1, ST_ACTIVE, 0, 1, "R10 aref open bank");
    step(1, CMD_NOP, 1, ST_ACTIVE, 0, 1, "R10 cke was low");
    step(1, CMD_NOP, 1, ST_ACTIVE, 0, 0, "R11");
    step(0, CMD_RD, 1, ST_ACTIVE, 0, 1, "R10 rd on fall");
    step(1, CMD_NOP, 1, ST_ACTIVE, 0, 1, "R10 cke was low");
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R2");

    // illegal exit command
    step(0, CMD_NOP, 0, ST_PDN, 0, 0, "R3");
    step(1, CMD_MRS, 0, ST_PDX, 0, 1, "R9 bad exit");
    step(1, CMD_NOP, 0, ST_PDX, 0, 0, "R9 window kept");
    step(1, CMD_NOP, 0, ST_PDX, 0, 0, "R9 window kept");
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R6");

    // zero-length power-down window
    xpnCycles = 8'd0;
    step(0, CMD_NOP, 1, ST_PDN, 1, 0, "R3");
    step(1, CMD_NOP, 0, ST_ACTIVE, 0, 0, "R6 zero window");

    // 1000-edge self-refresh window
    srxCycles = 16'd1000;
    step(1, CMD_NOP, 0, ST_IDLE, 0, 0, "R2");
    step(0, CMD_AREF, 0, ST_SREF, 0, 0, "R4");
    step(1, CMD_NOP, 0, ST_SRX, 0, 0, "R7 exit");
    for (int i = 1; i < 1000; i++) begin
      step(1, CMD_NOP, 0, ST_SRX, 0, 0, "R7 long window");
    end
    step(1, CMD_RD, 0, ST_IDLE, 0, 1, "R8 rd on last window edge");
    step(1, CMD_RD, 0, ST_IDLE, 0, 0, "R7 rd legal after window");

    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
    $finish;
  end

endmodule